// File: doc/BRIEF.md
# Menu-Driven SPI Flash Command Sequencer

This block runs one SPI flash transaction each time software sets the go bit in its control register. Software does not write the command byte directly. It picks one of eight command bytes from a programmable menu by index. A two-bit type entry for that menu slot sets the rest of the frame. One bit decides whether a 24-bit flash address follows the command. The other marks the command as a write or erase, which must run right after a write-enable prefix command.

The frame has the selected command byte, then an optional address, then 1 to 64 data bytes. Data bytes are either shifted out from a 64-byte buffer or captured into it. When an atomic pair is requested, a single-byte prefix frame taken from a two-entry prefix table runs first. Chip select is raised between the two frames. An external protection signal can refuse a cycle, and in that case no flash traffic is generated. A lock bit freezes the command tables until the next reset.

Top module: `spi_cycle_seq`

## Requirements
- R1: After reset the status word reads 0x0000, the prefix, type and menu registers read 0, chip select is high and the serial clock is low.
- R2: A control write with go (bit 1) set while no cycle is running sets the running flag (status bit 0) from the next clock until the last byte has finished. When the running flag clears, the done flag (status bit 2) is set and chip select is high.
- R3: The main frame sends menu[control[6:4]] first. If bit 2i+1 of the type word is set for slot i, three address bytes follow, most significant first. If control bit 14 is set, control[13:8]+1 data bytes follow. Register word map: 0 status, 1 control, 2 flash address, 3 prefix table (entry 0 in bits 7:0, entry 1 in bits 15:8), 4 type word, 5 menu slots 0-3, 6 menu slots 4-7 (slot k in bits 8(k%4)+7:8(k%4)).
- R4: With control bit 2 set, prefix[control[3]] is sent alone in its own chip-select frame before the main frame. Chip select stays high for at least one serial clock period between the two frames.
- R5: If type bit 2i is set, the data bytes are buffer bytes 0 upward. Otherwise the data phase is a read: MOSI sends zeros and the received bytes are stored in buffer bytes 0 upward.
- R6: Serial mode 0. The clock idles low and has a period of 2*SCK_HALF system clocks. MOSI sends the most significant bit first and is stable at each rising edge. MISO is sampled on the rising edge.
- R7: A go is refused, setting blocked (status bit 3) and leaving the running flag and chip select idle, when `refuse` is high or when the selected slot's type bit 2i is set but control bit 2 is clear.
- R8: Writing 1 to status bit 2 or bit 3 clears that flag. Writing 0 leaves it unchanged.
- R9: A control write while a cycle runs is ignored, including its go bit. An accepted go bit reads back as 0 after the cycle it was written.
- R10: Writing 1 to status bit 15 sets the lock, which only reset clears. While the lock is set, writes to the prefix, type and menu words are ignored.
- R11: Buffer byte 4w+j is at bits 8j+7:8j of register word 16+w. It can be written and read back, and the flash address reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| refuse | input | 1 | Protection logic refuses the requested access |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach is a control write that arrives while a cycle is in progress: it must change neither the latched command fields nor start a second transaction. The stimulus starts a long 64-byte read and writes a different go command partway through. It then checks that exactly one frame with the original command appeared and that the control word still holds its original fields. All eight menu slots are swept across data lengths of none, 1, 2, 5 and 64 bytes. The mix of type entries covers every address and direction combination, with and without the prefix frame.

// File: rtl/spi_cycle_seq.sv
module spi_cycle_seq #(
  parameter int SCK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        refuse,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam int BUF_BYTES = 64;
  localparam int DIV_W = $clog2(SCK_HALF + 1);
  localparam int GAP_W = $clog2(2 * SCK_HALF + 1);
  localparam logic [4:0] A_STAT = 5'd0, A_CTRL = 5'd1, A_ADDR = 5'd2, A_PFX = 5'd3,
                         A_TYPE = 5'd4, A_MENU0 = 5'd5, A_MENU1 = 5'd6;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP} st_t;

  logic        lock, done, blk, cip;
  logic [15:0] ctrl;
  logic [23:0] faddr;
  logic [7:0]  pfx  [2];
  logic [15:0] typ;
  logic [7:0]  menu [8];
  logic [7:0]  dbuf [BUF_BYTES];

  st_t              st;
  logic             in_pre;
  logic [6:0]       bnum;
  logic [2:0]       bitn;
  logic [7:0]       sh, rx;
  logic [DIV_W-1:0] div;
  logic [GAP_W-1:0] gapc;

  // decoded fields of the latched command
  logic [2:0]  idx;
  logic        psel, has_dat, t_addr, t_wr;
  logic [15:0] tsh, wtsh;
  logic [6:0]  hdr, dlen, last_b, frame_last;

  assign idx     = ctrl[6:4];
  assign psel    = ctrl[3];
  assign has_dat = ctrl[14];
  assign tsh     = typ >> {idx, 1'b0};
  assign t_wr    = tsh[0];
  assign t_addr  = tsh[1];
  assign hdr     = t_addr ? 7'd4 : 7'd1;
  assign dlen    = has_dat ? ({1'b0, ctrl[13:8]} + 7'd1) : 7'd0;
  assign last_b  = hdr + dlen - 7'd1;
  assign frame_last = in_pre ? 7'd0 : last_b;

  // host side decode
  logic ctrl_wr, go_ok, go_refused, cfg_ok;
  assign wtsh       = typ >> {reg_wdata[6:4], 1'b0};
  assign ctrl_wr    = reg_wr && reg_addr == A_CTRL && !cip;
  assign go_ok      = ctrl_wr && reg_wdata[1];
  assign go_refused = refuse || (wtsh[0] && !reg_wdata[2]);
  assign cfg_ok     = reg_wr && !lock;

  // shifter timing
  logic tick, fall, byte_end, store_en;
  assign tick     = st == S_SHIFT && div == DIV_W'(SCK_HALF - 1);
  assign fall     = tick && sck;
  assign byte_end = fall && bitn == 3'd7;
  assign store_en = byte_end && !in_pre && !t_wr && bnum >= hdr;
  assign mosi     = sh[7];

  function automatic logic [7:0] byte_of(input logic pre, input logic [6:0] n);
    if (pre)                           byte_of = pfx[psel];
    else if (n == 7'd0)                byte_of = menu[idx];
    else if (t_addr && n == 7'd1)      byte_of = faddr[23:16];
    else if (t_addr && n == 7'd2)      byte_of = faddr[15:8];
    else if (t_addr && n == 7'd3)      byte_of = faddr[7:0];
    else if (t_wr)                     byte_of = dbuf[6'(n - hdr)];
    else                               byte_of = 8'h00;
  endfunction

  // configuration and status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0; done <= 1'b0; blk <= 1'b0;
      ctrl <= '0; faddr <= '0; typ <= '0;
      pfx[0] <= '0; pfx[1] <= '0;
      for (int k = 0; k < 8; k++) menu[k] <= '0;
    end else begin
      if (ctrl_wr) ctrl <= reg_wdata[15:0];
      else         ctrl[1] <= 1'b0;
      if (reg_wr && reg_addr == A_ADDR) faddr <= reg_wdata[23:0];
      if (reg_wr && reg_addr == A_STAT) begin
        if (reg_wdata[2])  done <= 1'b0;
        if (reg_wdata[3])  blk  <= 1'b0;
        if (reg_wdata[15]) lock <= 1'b1;
      end
      if (cfg_ok && reg_addr == A_PFX) begin
        pfx[0] <= reg_wdata[7:0];
        pfx[1] <= reg_wdata[15:8];
      end
      if (cfg_ok && reg_addr == A_TYPE) typ <= reg_wdata[15:0];
      for (int k = 0; k < 4; k++) begin
        if (cfg_ok && reg_addr == A_MENU0) menu[k]     <= reg_wdata[8*k +: 8];
        if (cfg_ok && reg_addr == A_MENU1) menu[k + 4] <= reg_wdata[8*k +: 8];
      end
      if (go_ok && go_refused) blk <= 1'b1;
      if (byte_end && bnum == frame_last && !in_pre) done <= 1'b1;
    end
  end

  // data buffer: host word writes, engine byte stores
  always_ff @(posedge clk) begin
    for (int w = 0; w < BUF_BYTES / 4; w++)
      for (int j = 0; j < 4; j++)
        if (reg_wr && reg_addr == 5'(16 + w)) dbuf[4*w + j] <= reg_wdata[8*j +: 8];
    if (store_en) dbuf[6'(bnum - hdr)] <= rx;
  end

  // cycle engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cip <= 1'b0; in_pre <= 1'b0; cs_n <= 1'b1; sck <= 1'b0;
      bnum <= '0; bitn <= '0; sh <= '0; rx <= '0; div <= '0; gapc <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_ok && !go_refused) begin
          st     <= S_LOAD;
          cip    <= 1'b1;
          in_pre <= reg_wdata[2];
        end
        S_LOAD: begin
          cs_n <= 1'b0;
          sck  <= 1'b0;
          sh   <= byte_of(in_pre, 7'd0);
          bnum <= '0;
          bitn <= '0;
          div  <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!tick) div <= div + 1'b1;
          else begin
            div <= '0;
            if (!sck) begin
              sck <= 1'b1;
              rx  <= {rx[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (bitn != 3'd7) begin
                bitn <= bitn + 1'b1;
                sh   <= {sh[6:0], 1'b0};
              end else if (bnum != frame_last) begin
                bitn <= '0;
                bnum <= bnum + 1'b1;
                sh   <= byte_of(in_pre, bnum + 7'd1);
              end else begin
                cs_n <= 1'b1;
                if (in_pre) begin
                  in_pre <= 1'b0;
                  gapc   <= '0;
                  st     <= S_GAP;
                end else begin
                  cip <= 1'b0;
                  st  <= S_IDLE;
                end
              end
            end
          end
        end
        S_GAP: begin
          gapc <= gapc + 1'b1;
          if (gapc == GAP_W'(2 * SCK_HALF - 1)) st <= S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      for (int j = 0; j < 4; j++) reg_rdata[8*j +: 8] = dbuf[{reg_addr[3:0], 2'(j)}];
    end else begin
      case (reg_addr)
        A_STAT:  reg_rdata = {16'd0, lock, 11'd0, blk, done, 1'b0, cip};
        A_CTRL:  reg_rdata = {16'd0, ctrl};
        A_ADDR:  reg_rdata = {8'd0, faddr};
        A_PFX:   reg_rdata = {16'd0, pfx[1], pfx[0]};
        A_TYPE:  reg_rdata = {16'd0, typ};
        A_MENU0: reg_rdata = {menu[3], menu[2], menu[1], menu[0]};
        A_MENU1: reg_rdata = {menu[7], menu[6], menu[5], menu[4]};
        default: reg_rdata = '0;
      endcase
    end
  end

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) !cip |-> cs_n);
  assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n) $fell(cip) |-> done);
  assert_sck_parked_R6: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n) $rose(blk) |-> (cs_n && !cip));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cip && reg_wr && reg_addr == A_CTRL) |=> $stable(ctrl[15:2]));
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n) $past(lock) |-> lock);

endmodule

// File: tb/tb_spi_cycle_seq.sv
module tb_spi_cycle_seq;
  localparam int SCK_HALF = 2;
  localparam int PER_NS = 2 * SCK_HALF * 10;
  localparam logic [15:0] TYPEV = 16'h4F62;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic refuse = 1'b0, miso = 1'b0;
  logic sck, cs_n, mosi;

  int tests = 0, fails = 0;

  spi_cycle_seq #(.SCK_HALF(SCK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .refuse(refuse), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  // flash model / monitor
  int fcnt, lcnt, bitc;
  int flen [8];
  logic [7:0] lg [0:159];
  logic [7:0] shr;
  time t_cs_hi, last_rise, min_gap, min_per, max_per;
  bit first_rise, mon_on = 0;

  function automatic logic [7:0] pat(input int k);
    return 8'h5A ^ 8'(k * 13);
  endfunction
  function automatic logic [7:0] menuv(input int i);
    return 8'(8'h11 * i + 8'h03);
  endfunction
  function automatic logic [7:0] bp(input int j, input int i);
    return 8'(j * 7 + i * 16 + 1);
  endfunction

  always @(negedge cs_n) if (mon_on) begin
    if (fcnt > 0 && ($time - t_cs_hi) < min_gap) min_gap = $time - t_cs_hi;
    bitc = 0; first_rise = 1; miso = pat(0)[7];
  end
  always @(posedge cs_n) if (mon_on) begin
    t_cs_hi = $time;
    if (fcnt < 8) flen[fcnt] = bitc / 8;
    fcnt++;
  end
  always @(posedge sck) if (mon_on && !cs_n) begin
    if (!first_rise) begin
      if ($time - last_rise < min_per) min_per = $time - last_rise;
      if ($time - last_rise > max_per) max_per = $time - last_rise;
    end
    first_rise = 0; last_rise = $time;
    shr = {shr[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0 && lcnt < 160) begin lg[lcnt] = shr; lcnt++; end
  end
  always @(negedge sck) if (mon_on && !cs_n) miso = pat(bitc / 8)[7 - (bitc % 8)];

  task automatic clear_mon();
    fcnt = 0; lcnt = 0; bitc = 0; min_gap = 1000000; min_per = 1000000; max_per = 0;
    mon_on = 1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(5'd0, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [15:0] ctl(input int idx, input bit atom, input bit psel, input int cnt);
    logic [15:0] c;
    c = 16'h0003;
    c[6:4] = 3'(idx); c[3] = psel; c[2] = atom;
    if (cnt > 0) begin c[14] = 1'b1; c[13:8] = 6'(cnt - 1); end
    return c;
  endfunction

  task automatic do_reset();
    mon_on = 0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic program_tables();
    wr(5'd3, 32'h0000_4EC1);
    wr(5'd4, {16'd0, TYPEV});
    wr(5'd5, {menuv(3), menuv(2), menuv(1), menuv(0)});
    wr(5'd6, {menuv(7), menuv(6), menuv(5), menuv(4)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] c0;
    int cvals [5] = '{0, 1, 2, 5, 64};
    do_reset();

    // R1 reset state
    rd(5'd0, r); check(r == 0, "R1 status", r, 0);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 pins", {cs_n, sck}, 2'b10);
    rd(5'd3, r); check(r == 0, "R1 prefix", r, 0);

    program_tables();
    rd(5'd5, r); check(r == {menuv(3), menuv(2), menuv(1), menuv(0)}, "R3 menu readback", r, 0);
    wr(5'd2, 32'h00AB_CDEF);
    rd(5'd2, r); check(r == 32'h00AB_CDEF, "R11 address readback", r, 32'h00AB_CDEF);
    wr(5'd21, 32'hDEAD_BEEF);
    rd(5'd21, r); check(r == 32'hDEAD_BEEF, "R11 buffer word", r, 32'hDEAD_BEEF);

    // sweep of menu slots and lengths
    for (int i = 0; i < 8; i++) begin
      for (int ci = 0; ci < 5; ci++) begin
        int cnt, hdr, base;
        bit ta, tw, atom, psel;
        logic [23:0] fa;
        cnt = cvals[ci];
        ta = TYPEV[2*i+1]; tw = TYPEV[2*i];
        atom = tw || (i == 2); psel = i[0];
        hdr = ta ? 4 : 1; base = atom ? 1 : 0;
        fa = 24'h123456 ^ 24'(i << 16) ^ 24'(cnt);
        wr(5'd2, {8'd0, fa});
        if (tw)
          for (int w = 0; w < 16; w++)
            wr(5'(16 + w), {bp(4*w+3, i), bp(4*w+2, i), bp(4*w+1, i), bp(4*w, i)});
        clear_mon();
        wr(5'd1, {16'd0, ctl(i, atom, psel, cnt)});
        rd(5'd0, r); check(r[0] == 1'b1, "R2 running after go", r, 1);
        wait_idle();
        repeat (4) @(negedge clk);
        rd(5'd0, r); check(r == 32'h4, "R2 done status", r, 32'h4);
        if (i == 0 && ci == 0) begin
          wr(5'd0, 32'h0); rd(5'd0, r); check(r == 32'h4, "R8 zero write keeps done", r, 32'h4);
          rd(5'd1, r); check(r[1] == 1'b0, "R9 go self-clears", r, 0);
        end
        wr(5'd0, 32'h4); rd(5'd0, r); check(r == 0, "R8 done cleared", r, 0);
        check(fcnt == base + 1, "R4 frame count", fcnt, base + 1);
        if (atom) begin
          check(flen[0] == 1, "R4 prefix frame length", flen[0], 1);
          check(lg[0] == (psel ? 8'h4E : 8'hC1), "R4 prefix byte", lg[0], psel ? 8'h4E : 8'hC1);
          check(min_gap >= PER_NS, "R4 gap", 32'(min_gap), PER_NS);
        end
        check(flen[base] == hdr + cnt, "R3 frame length", flen[base], hdr + cnt);
        check(lg[base] == menuv(i), "R3 opcode", lg[base], menuv(i));
        if (ta) begin
          check(lg[base+1] == fa[23:16], "R3 addr hi", lg[base+1], fa[23:16]);
          check(lg[base+2] == fa[15:8], "R3 addr mid", lg[base+2], fa[15:8]);
          check(lg[base+3] == fa[7:0], "R3 addr lo", lg[base+3], fa[7:0]);
        end
        for (int j = 0; j < cnt; j++) begin
          if (tw) check(lg[base+hdr+j] == bp(j, i), "R5 write byte", lg[base+hdr+j], bp(j, i));
          else    check(lg[base+hdr+j] == 8'h00, "R5 read mosi low", lg[base+hdr+j], 0);
        end
        if (!tw)
          for (int j = 0; j < cnt; j++) begin
            rd(5'(16 + j / 4), r);
            check(r[8*(j%4) +: 8] == pat(hdr + j), "R5 read store", r[8*(j%4) +: 8], pat(hdr + j));
          end
        check(min_per == PER_NS && max_per == PER_NS, "R6 sck period", 32'(max_per), PER_NS);
      end
    end

    // R7 refused by protection input
    clear_mon();
    refuse = 1'b1;
    wr(5'd1, {16'd0, ctl(1, 0, 0, 4)});
    refuse = 1'b0;
    repeat (40) @(negedge clk);
    rd(5'd0, r); check(r == 32'h8, "R7 blocked by refuse", r, 32'h8);
    check(fcnt == 0, "R7 no traffic", fcnt, 0);
    wr(5'd0, 32'h4); rd(5'd0, r); check(r == 32'h8, "R8 other bit keeps blocked", r, 32'h8);
    wr(5'd0, 32'h8); rd(5'd0, r); check(r == 0, "R8 blocked cleared", r, 0);

    // R7 write slot without atomic request
    clear_mon();
    wr(5'd1, {16'd0, ctl(4, 0, 1, 2)});
    repeat (40) @(negedge clk);
    rd(5'd0, r); check(r == 32'h8, "R7 blocked missing prefix", r, 32'h8);
    check(fcnt == 0, "R7 no traffic missing prefix", fcnt, 0);
    wr(5'd0, 32'h8);

    // R9 go while busy
    clear_mon();
    c0 = ctl(0, 0, 0, 64);
    wr(5'd1, {16'd0, c0});
    repeat (20) @(negedge clk);
    wr(5'd1, {16'd0, ctl(6, 1, 1, 3)});
    wait_idle();
    repeat (60) @(negedge clk);
    check(fcnt == 1, "R9 single frame", fcnt, 1);
    check(lg[0] == menuv(0), "R9 original opcode", lg[0], menuv(0));
    check(flen[0] == 68, "R9 original length", flen[0], 68);
    rd(5'd1, r); check(r[15:0] == (c0 & 16'hFFFD), "R9 control unchanged", r, c0 & 16'hFFFD);
    wr(5'd0, 32'h4);

    // R10 lock
    wr(5'd0, 32'h8000);
    rd(5'd0, r); check(r == 32'h8000, "R10 lock set", r, 32'h8000);
    wr(5'd3, 32'h0000_1111);
    wr(5'd4, 32'h0000_0000);
    wr(5'd6, 32'h0);
    rd(5'd3, r); check(r == 32'h4EC1, "R10 prefix frozen", r, 32'h4EC1);
    rd(5'd4, r); check(r == {16'd0, TYPEV}, "R10 type frozen", r, TYPEV);
    rd(5'd6, r); check(r == {menuv(7), menuv(6), menuv(5), menuv(4)}, "R10 menu frozen", r, 0);
    wr(5'd0, 32'h0);
    rd(5'd0, r); check(r[15] == 1'b1, "R10 lock sticky", r, 32'h8000);
    do_reset();
    rd(5'd0, r); check(r == 0, "R1 R10 reset clears lock", r, 0);
    rd(5'd4, r); check(r == 0, "R1 type after reset", r, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule